// File: doc/BRIEF.md
# Register-List Stack Save/Restore Sequencer

This block moves a chosen set of processor registers between a register file and a word-wide memory port. Software-visible instruction handling happens elsewhere: the caller hands the sequencer a start pulse together with a direction (save or restore), an 8-bit register-list mask, a base stack pointer and an optional 8-bit frame size. The sequencer then issues one 32-bit memory access per selected register and returns a one-cycle done pulse that carries the final stack pointer, which the caller writes back.

Save walks the selection from the first slot to the last and writes each register one word below the previous one, so the stack grows downward. Restore walks the same slots in exactly the opposite order and reads upward from the start pointer, so a restore started at the pointer a save ended with brings every register back. A restore can first add the frame size to the base, which releases a local frame before the registers are read.

The controller has three states. ST_IDLE waits for start. From ST_IDLE, a start with at least one selected register goes to ST_XFER, and a start with none goes straight to ST_DONE. ST_XFER holds one memory request until ready. On ready it stays in ST_XFER when more registers remain, or moves to ST_DONE after the last one. ST_DONE raises done for one cycle and always returns to ST_IDLE.

Top module: `regstack_seq`

## Requirements
- R1: After reset the block is idle: busy, done, memory request and register-file write are all low and the stack pointer output is zero.
- R2: Mask bit 7 selects register code 2, bit 6 code 3, bit 5 code 6 and bit 4 code 7. Bit 3 selects the group of codes 0, 1, 4, 5, 8, 9 and 10 as one unit. Bits 2 to 0 have no effect.
- R3: In save mode, the registers are read on the register-file read port and written to memory in the slot order 2, 3, 6, 7, 0, 1, 4, 5, 8, 9, 10, skipping unselected ones, and the write data is the register value.
- R4: In save mode, each write goes to the current pointer minus 4, and the pointer then takes that value. The first write is at base minus 4 and the final pointer is base minus 4 times the register count.
- R5: In restore mode the slot order is the exact reverse of R3: 10, 9, 8, 5, 4, 1, 0, 7, 6, 3, 2.
- R6: In restore mode, the first read is at the start pointer and each further read is 4 bytes higher. The final pointer is the start pointer plus 4 times the register count.
- R7: In restore mode with the frame enable high, the start pointer is the base plus the zero-extended 8-bit frame size. In save mode the frame size and enable have no effect.
- R8: A memory request keeps its address, direction and data stable until the cycle in which ready is high. Exactly one word moves in that cycle, and no request is raised beyond the selected registers.
- R9: Done is high for exactly one cycle, in the cycle after the last transfer completes, and the stack pointer output then holds the final pointer.
- R10: A start with mask bits 7 to 3 all clear raises done in the next cycle without any memory request, and the final pointer is the start pointer.
- R11: A start pulse while busy is high (including the done cycle) is ignored and does not disturb the sequence in progress.
- R12: In restore mode the register file is written in the cycle the read completes, with the memory read data at the register code of R5. Save mode never writes the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, accepted only when idle |
| restore_i | input | 1 | 0 = save, 1 = restore |
| adj_en_i | input | 1 | Add frame size to base before a restore |
| mask_i | input | 8 | Register-list mask |
| frame_i | input | FRAME_W (8) | Unsigned frame size |
| base_i | input | ADDR_W (32) | Base stack pointer |
| busy_o | output | 1 | Sequence in progress (high from the cycle after start through done) |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | ADDR_W (32) | Stack pointer, final value valid with done |
| rf_rd_idx_o | output | 4 | Register-file read code |
| rf_rd_data_i | input | DATA_W (32) | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | 4 | Register-file write code |
| rf_wr_data_o | output | DATA_W (32) | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W (32) | Memory byte address |
| mem_wdata_o | output | DATA_W (32) | Memory write data |
| mem_rdata_i | input | DATA_W (32) | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory ready, completes the request |

## Verification
The hardest case is a memory that stalls at uneven points in the middle of a long walk, while a second start arrives during the stall. Address, data and direction must then hold, the pending set must not be reloaded, and done must still land exactly one cycle after the final word. To reach it, the bench toggles ready pseudo-randomly and issues a conflicting start in the middle of a full eleven-register save. It also chains every save into a restore that begins at the pointer the save returned, and into a frame-adjusted restore from a lower base, so that the reverse ordering is confirmed by registers actually coming back.

// File: rtl/regstack_pkg.sv
package regstack_pkg;

    localparam int IDX_W      = 4;   // register code width
    localparam int NSLOT      = 11;  // walk slots: 4 singles + 7 group members
    localparam int NSINGLE    = 4;   // slots selected one bit each
    localparam int GROUP_BIT  = 3;   // mask bit choosing the group
    localparam int SINGLE_TOP = 7;   // mask bit of slot 0

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

    typedef enum logic {
        DIR_SAVE    = 1'b0,
        DIR_RESTORE = 1'b1
    } dir_t;

    // register code held by each walk slot (save order)
    function automatic logic [IDX_W-1:0] slot_reg(input int unsigned slot);
        logic [IDX_W-1:0] code;
        unique case (slot)
            0:       code = 4'd2;
            1:       code = 4'd3;
            2:       code = 4'd6;
            3:       code = 4'd7;
            4:       code = 4'd0;
            5:       code = 4'd1;
            6:       code = 4'd4;
            7:       code = 4'd5;
            8:       code = 4'd8;
            9:       code = 4'd9;
            default: code = 4'd10;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/regstack_expand.sv
module regstack_expand
    import regstack_pkg::*;
(
    input  logic [7:0]       mask_i,
    output logic [NSLOT-1:0] slots_o
);
    // slots 0..NSINGLE-1 take one mask bit each, from the top bit down;
    // the remaining slots all follow the group bit
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (g < NSINGLE) begin : g_single
            assign slots_o[g] = mask_i[SINGLE_TOP - g];
        end else begin : g_group
            assign slots_o[g] = mask_i[GROUP_BIT];
        end
    end
endmodule

// File: rtl/regstack_pick.sv
module regstack_pick #(
    parameter int N  = 11,
    parameter int IW = $clog2(N)
) (
    input  logic          from_top_i,
    input  logic [N-1:0]  vec_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] pos_o,
    output logic          any_o,
    output logic          multi_o
);
    logic found;

    always_comb begin
        grant_o = '0;
        pos_o   = '0;
        found   = 1'b0;
        if (!from_top_i) begin
            for (int i = 0; i < N; i++) begin
                if (vec_i[i] && !found) begin
                    grant_o[i] = 1'b1;
                    pos_o      = IW'(i);
                    found      = 1'b1;
                end
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (vec_i[i] && !found) begin
                    grant_o[i] = 1'b1;
                    pos_o      = IW'(i);
                    found      = 1'b1;
                end
            end
        end
    end

    assign any_o   = |vec_i;
    assign multi_o = |(vec_i & (vec_i - N'(1)));

    always_comb begin
        AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R3
        AST_GRANT_IN_SET: assert ((grant_o & ~vec_i) == '0); // R5
    end
endmodule

// File: rtl/regstack_ptr.sv
module regstack_ptr #(
    parameter int ADDR_W     = 32,
    parameter int FRAME_W    = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               use_frame_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               step_i,
    input  logic               up_i,
    output logic [ADDR_W-1:0]  ptr_o,
    output logic [ADDR_W-1:0]  ptr_dn_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] start_val;

    assign start_val = use_frame_i ? base_i + ADDR_W'(frame_i) : base_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= start_val;
        end else if (step_i) begin
            ptr_q <= up_i ? ptr_q + STEP : ptr_q - STEP;
        end
    end

    assign ptr_o    = ptr_q;
    assign ptr_dn_o = ptr_q - STEP;
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
    import regstack_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int FRAME_W    = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               restore_i,
    input  logic               adj_en_i,
    input  logic [7:0]         mask_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [ADDR_W-1:0]  base_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [ADDR_W-1:0]  sp_o,
    output logic [IDX_W-1:0]   rf_rd_idx_o,
    input  logic [DATA_W-1:0]  rf_rd_data_i,
    output logic               rf_we_o,
    output logic [IDX_W-1:0]   rf_wr_idx_o,
    output logic [DATA_W-1:0]  rf_wr_data_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    input  logic               mem_ready_i
);
    localparam int POS_W = $clog2(NSLOT);

    seq_state_t         state_q, state_d;
    dir_t               dir_q;
    logic [NSLOT-1:0]   pend_q;
    logic [NSLOT-1:0]   slots;
    logic [NSLOT-1:0]   grant;
    logic [POS_W-1:0]   pos;
    logic               pend_any;
    logic               pend_multi;
    logic               accept;
    logic               fire;
    logic [ADDR_W-1:0]  ptr;
    logic [ADDR_W-1:0]  ptr_dn;
    logic [IDX_W-1:0]   cur_reg;

    regstack_expand u_expand (
        .mask_i  (mask_i),
        .slots_o (slots)
    );

    regstack_pick #(.N(NSLOT), .IW(POS_W)) u_pick (
        .from_top_i (dir_q == DIR_RESTORE),
        .vec_i      (pend_q),
        .grant_o    (grant),
        .pos_o      (pos),
        .any_o      (pend_any),
        .multi_o    (pend_multi)
    );

    regstack_ptr #(
        .ADDR_W     (ADDR_W),
        .FRAME_W    (FRAME_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .use_frame_i (restore_i & adj_en_i),
        .base_i      (base_i),
        .frame_i     (frame_i),
        .step_i      (fire),
        .up_i        (dir_q == DIR_RESTORE),
        .ptr_o       (ptr),
        .ptr_dn_o    (ptr_dn)
    );

    assign accept  = (state_q == ST_IDLE) && start_i;
    assign fire    = (state_q == ST_XFER) && mem_ready_i;
    assign cur_reg = slot_reg(32'(pos));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // pending set and direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            dir_q  <= DIR_SAVE;
        end else if (accept) begin
            pend_q <= slots;
            dir_q  <= restore_i ? DIR_RESTORE : DIR_SAVE;
        end else if (fire) begin
            pend_q <= pend_q & ~grant;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (|slots) ? ST_XFER : ST_DONE;
                end
            end
            ST_XFER: begin
                if (mem_ready_i && !pend_multi) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy_o       = 1'b1;
        done_o       = 1'b0;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = ptr;
        mem_wdata_o  = rf_rd_data_i;
        rf_rd_idx_o  = cur_reg;
        rf_we_o      = 1'b0;
        rf_wr_idx_o  = cur_reg;
        rf_wr_data_o = mem_rdata_i;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_XFER: begin
                mem_req_o = pend_any;
                if (dir_q == DIR_SAVE) begin
                    mem_we_o   = 1'b1;
                    mem_addr_o = ptr_dn;
                end else begin
                    mem_addr_o = ptr;
                    rf_we_o    = mem_ready_i;
                end
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b1;
            end
        endcase
    end

    assign sp_o = ptr;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !done_o && !rf_we_o)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(rf_rd_idx_o))); // R8

    AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && mem_we_o && pend_multi)
            |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) - ADDR_W'(WORD_BYTES))); // R4

    AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && !mem_we_o && pend_multi)
            |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(WORD_BYTES))); // R6

    AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && restore_i && adj_en_i)
            |=> (sp_o == $past(base_i) + ADDR_W'($past(frame_i)))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mask_i[7:3] == 5'd0) |=> (done_o && !mem_req_o)); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o))); // R11

    AST_RF_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o)); // R12

endmodule

// File: tb/regstack_seq_tb.sv
module regstack_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        restore_i;
    logic        adj_en_i;
    logic [7:0]  mask_i;
    logic [7:0]  frame_i;
    logic [31:0] base_i;
    logic        busy_o;
    logic        done_o;
    logic [31:0] sp_o;
    logic [3:0]  rf_rd_idx_o;
    logic [31:0] rf_rd_data_i;
    logic        rf_we_o;
    logic [3:0]  rf_wr_idx_o;
    logic [31:0] rf_wr_data_o;
    logic        mem_req_o;
    logic        mem_we_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i;
    logic        mem_ready_i;

    always #4 clk = ~clk;   // 125 MHz

    regstack_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .restore_i    (restore_i),
        .adj_en_i     (adj_en_i),
        .mask_i       (mask_i),
        .frame_i      (frame_i),
        .base_i       (base_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .sp_o         (sp_o),
        .rf_rd_idx_o  (rf_rd_idx_o),
        .rf_rd_data_i (rf_rd_data_i),
        .rf_we_o      (rf_we_o),
        .rf_wr_idx_o  (rf_wr_idx_o),
        .rf_wr_data_o (rf_wr_data_o),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rdata_i  (mem_rdata_i),
        .mem_ready_i  (mem_ready_i)
    );

    // behavioural register file and memory
    logic [31:0] regs     [0:15];
    logic [31:0] exp_regs [0:15];
    logic [31:0] mem      [0:63];

    assign rf_rd_data_i = regs[rf_rd_idx_o];
    assign mem_rdata_i  = mem[mem_addr_o[7:2]];

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [3:0]  idx;
        logic [31:0] data;
    } xfer_t;

    xfer_t       q[$];
    int          errors = 0;
    int          checks = 0;
    bit          expect_done = 1'b0;
    bit          cur_restore = 1'b0;
    bit          ready_rand  = 1'b0;
    bit          prev_stall  = 1'b0;
    logic [31:0] prev_addr   = '0;
    logic [31:0] exp_sp      = '0;
    bit          finished    = 1'b0;

    int order_reg [11] = '{2, 3, 6, 7, 0, 1, 4, 5, 8, 9, 10};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit slot_sel(input logic [7:0] m, input int k);
        return (k < 4) ? m[7 - k] : m[3];
    endfunction

    // reference plan built from the requirements
    task automatic plan(input bit mode, input logic [7:0] m, input logic [31:0] base,
                        input bit adj, input logic [7:0] fr);
        logic [31:0] p;
        xfer_t e;
        q.delete();
        p = (mode && adj) ? base + {24'd0, fr} : base;
        for (int r = 0; r < 16; r++) exp_regs[r] = regs[r];
        if (!mode) begin
            for (int k = 0; k < 11; k++) begin
                if (slot_sel(m, k)) begin
                    p = p - 32'd4;
                    e.we = 1'b1; e.addr = p; e.idx = 4'(order_reg[k]);
                    e.data = regs[order_reg[k]];
                    q.push_back(e);
                end
            end
        end else begin
            for (int k = 10; k >= 0; k--) begin
                if (slot_sel(m, k)) begin
                    e.we = 1'b0; e.addr = p; e.idx = 4'(order_reg[k]);
                    e.data = mem[p[7:2]];
                    exp_regs[order_reg[k]] = mem[p[7:2]];
                    q.push_back(e);
                    p = p + 32'd4;
                end
            end
        end
        exp_sp      = p;
        cur_restore = mode;
    endtask

    // ready driver
    always @(negedge clk) begin
        mem_ready_i <= ready_rand ? (($urandom % 3) != 0) : 1'b1;
    end

    // cycle monitor, sampled just before each rising edge
    always @(negedge clk) begin
        xfer_t e;
        #3;
        if (rst_n && !finished) begin
            if (expect_done) begin
                check(done_o === 1'b1, "R9", "done after last word", {31'd0, done_o}, 32'd1);
                check(sp_o == exp_sp, "R9", "final sp", sp_o, exp_sp);
                expect_done = 1'b0;
            end else if (done_o) begin
                check(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
            end
            if (prev_stall) begin
                check(mem_req_o && mem_addr_o == prev_addr, "R8", "held address",
                      mem_addr_o, prev_addr);
            end
            prev_stall = mem_req_o && !mem_ready_i;
            prev_addr  = mem_addr_o;
            if (start_i && !busy_o && q.size() == 0) expect_done = 1'b1;
            if (mem_req_o && mem_ready_i) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", "extra transfer", mem_addr_o, 32'd0);
                end else begin
                    e = q.pop_front();
                    check(mem_we_o == e.we, "R12", "direction", {31'd0, mem_we_o}, {31'd0, e.we});
                    check(mem_addr_o == e.addr, cur_restore ? "R6" : "R4", "address",
                          mem_addr_o, e.addr);
                    if (!cur_restore) begin
                        check(rf_rd_idx_o == e.idx, "R3", "save register code",
                              {28'd0, rf_rd_idx_o}, {28'd0, e.idx});
                        check(mem_wdata_o == e.data, "R3", "save data", mem_wdata_o, e.data);
                        mem[mem_addr_o[7:2]] = mem_wdata_o;
                    end else begin
                        check(rf_we_o && rf_wr_idx_o == e.idx, "R5", "restore register code",
                              {28'd0, rf_wr_idx_o}, {28'd0, e.idx});
                        check(rf_wr_data_o == e.data, "R12", "restore data",
                              rf_wr_data_o, e.data);
                    end
                    if (q.size() == 0) expect_done = 1'b1;
                end
            end
            if (rf_we_o) begin
                if (!(cur_restore && mem_req_o && mem_ready_i))
                    check(1'b0, "R12", "stray register write", {28'd0, rf_wr_idx_o}, 32'd0);
                regs[rf_wr_idx_o] = rf_wr_data_o;
            end
        end
    end

    task automatic run(input bit mode, input logic [7:0] m, input logic [31:0] base,
                       input bit adj, input logic [7:0] fr, input bit poke);
        int guard;
        plan(mode, m, base, adj, fr);
        @(negedge clk);
        start_i = 1'b1; restore_i = mode; mask_i = m; base_i = base;
        adj_en_i = adj; frame_i = fr;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R11: conflicting start while busy
            @(negedge clk);
            start_i = 1'b1; restore_i = ~mode; mask_i = 8'hFF;
            base_i = base ^ 32'h40; adj_en_i = 1'b1; frame_i = 8'h3C;
            @(negedge clk);
            start_i = 1'b0;
        end
        guard = 0;
        while (busy_o && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        check(q.size() == 0, "R9", "all planned words moved", q.size(), 32'd0);
        for (int r = 0; r < 11; r++)
            check(regs[r] == exp_regs[r], mode ? "R12" : "R3", "register file",
                  regs[r], exp_regs[r]);
    endtask

    task automatic fill_regs(input logic [31:0] seed);
        for (int r = 0; r < 16; r++) regs[r] = seed ^ (32'h0101_0101 * r) ^ {r[7:0], 24'h0};
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [7:0]  rm;
        logic [31:0] rb;
        logic [31:0] endp;
        start_i = 0; restore_i = 0; adj_en_i = 0; mask_i = 0; frame_i = 0; base_i = 0;
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 + i * 32'h0001_0003;
        fill_regs(32'h1357_9BDF);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o, "R1", "busy", {31'd0, busy_o}, 32'd0);
        check(!mem_req_o, "R1", "mem request", {31'd0, mem_req_o}, 32'd0);
        check(!done_o, "R1", "done", {31'd0, done_o}, 32'd0);
        check(!rf_we_o, "R1", "rf write", {31'd0, rf_we_o}, 32'd0);
        check(sp_o == 32'd0, "R1", "sp", sp_o, 32'd0);

        // R3 R4: full save, always-ready memory
        run(1'b0, 8'hF8, 32'h0000_0100, 1'b0, 8'h00, 1'b0);
        // R5 R6 R12: scramble then restore from the pointer the save ended at
        fill_regs(32'hDEAD_0000);
        run(1'b1, 8'hF8, 32'h0000_0100 - 32'd44, 1'b0, 8'h00, 1'b0);

        // R7: save two singles, restore with frame release
        ready_rand = 1'b1;
        run(1'b0, 8'h90, 32'h0000_0088, 1'b0, 8'h00, 1'b0);
        fill_regs(32'h0BAD_F00D);
        run(1'b1, 8'h90, 32'h0000_0070, 1'b1, 8'h10, 1'b0);
        // R7: frame fields ignored in save mode
        run(1'b0, 8'h60, 32'h0000_00C0, 1'b1, 8'h20, 1'b0);

        // R10 R2: empty selections, low bits ignored
        run(1'b0, 8'h00, 32'h0000_0040, 1'b0, 8'h00, 1'b0);
        run(1'b0, 8'h07, 32'h0000_0040, 1'b0, 8'h00, 1'b0);
        run(1'b1, 8'h05, 32'h0000_0020, 1'b1, 8'h08, 1'b0);
        // R2: only code 3 despite low bits
        run(1'b0, 8'h47, 32'h0000_0080, 1'b0, 8'h00, 1'b0);
        // R2: group alone
        run(1'b0, 8'h08, 32'h0000_00F0, 1'b0, 8'h00, 1'b0);

        // R11: start pulse while busy, deterministic ready
        ready_rand = 1'b0;
        run(1'b0, 8'hF8, 32'h0000_0100, 1'b0, 8'h00, 1'b1);
        ready_rand = 1'b1;
        run(1'b1, 8'hF8, 32'h0000_00D4, 1'b0, 8'h00, 1'b1);

        // R8 and round trips with stalls
        for (int n = 0; n < 16; n++) begin
            rm = 8'($urandom);
            rb = 32'h0000_0100 + {26'd0, 4'($urandom), 2'b00};
            fill_regs($urandom);
            run(1'b0, rm, rb, n[0], 8'($urandom), 1'b0);
            endp = exp_sp;
            fill_regs($urandom);
            run(1'b1, rm, endp, 1'b0, 8'h00, 1'b0);
        end

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule